// File: doc/BRIEF.md
# Phase comparator with lock flag, pump mode control and status mux

This block sits between the two dividers of a synthesizer channel and the analog charge pump. A programmable reference divider running on the reference clock produces a one-cycle comparison tick. A phase-frequency comparator then measures how far that tick leads or lags the one-cycle feedback pulse from the loop's own divider. The result is an up or down command whose width, in clock cycles, equals the phase error.

Mode inputs control what the pump sees. One input sets the sign convention for the VCO's tuning slope. Another forces the pump outputs into high impedance. A third requests the fourfold "boost" current used while the loop acquires. A lock detector watches the error pulse widths and drives a status pin. That pin can show this loop's lock, the combined lock of this loop and a sibling loop, or act as an open-drain pull-down while boost is active. A powerdown request and a return from boost to normal current both wait until the pump is idle, so the charge on the loop filter is not disturbed. The reference divider halts only when this channel and the sibling channel are both powered down.

Top module: `pll_phase_detect`

## Requirements
- R1: With `ref_ratio` = N ≥ 3 and the divider running, `ref_tick` is high for exactly one cycle every N cycles. The first tick comes in the first cycle after reset, and a new ratio takes effect at the next tick.
- R2: A `ref_ratio` below 3 divides by 3, so two ticks are never less than 3 cycles apart.
- R3: The comparator's lead flag is set the cycle after a tick and its lag flag the cycle after a feedback pulse. Once both would be set, both clear in that same cycle, so the pump sees a pulse whose width equals the lag in cycles, and coincident inputs give no pulse. `pump_up` and `pump_dn` are never high together.
- R4: With `pol_pos` = 1, the lead flag drives `pump_up` and the lag flag drives `pump_dn`. With `pol_pos` = 0 they are swapped.
- R5: While `cp_tri` = 1 or the channel is powered down, `pump_tri` = 1 and `pump_up` = `pump_dn` = 0.
- R6: `lock` rises after LOCK_N ticks with no error pulse reaching THRESH cycles. An error pulse that reaches THRESH cycles clears `lock` in the next cycle. Powerdown also clears it.
- R7: The lock indication on the status pin is `lock` with the pin held low in every cycle where an error pulse is active.
- R8: `stat_sel` encoding: 0 drives the pin low (`stat_drive`=1, `stat_val`=0). 1 drives this loop's lock indication. 2 drives that indication ANDed with `other_lock`. 3 gives open drain (`stat_val`=0, `stat_drive` = `pump_hi`).
- R9: `pump_hi` rises the cycle after `cp_hi` = 1. After `cp_hi` returns to 0, `pump_hi` falls only in the cycle after one in which no error pulse is active.
- R10: With `pd_req` = 1, `chan_off` rises in the cycle after the first one with no error pulse active. Clearing `pd_req` clears `chan_off` in the next cycle. While `chan_off` is high, ticks and feedback pulses do not set the comparator.
- R11: The divider halts, with no ticks, only while `chan_off` and `other_pd` are both 1. It resumes with a tick in the first cycle either one drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_pulse | input | 1 | One-cycle pulse from the feedback divider |
| ref_ratio | input | RW | Reference division ratio |
| pol_pos | input | 1 | 1 for rising VCO tuning slope |
| cp_hi | input | 1 | Boost current request |
| cp_tri | input | 1 | Force pump to high impedance |
| pd_req | input | 1 | Powerdown request for this channel |
| other_pd | input | 1 | Sibling channel is powered down |
| other_lock | input | 1 | Sibling loop lock indication |
| stat_sel | input | 2 | Status pin source select |
| pump_up | output | 1 | Pump source command |
| pump_dn | output | 1 | Pump sink command |
| pump_tri | output | 1 | Pump high-impedance enable |
| pump_hi | output | 1 | High (4x) current select |
| stat_val | output | 1 | Status pin value when driven |
| stat_drive | output | 1 | Status pin output enable |
| ref_tick | output | 1 | Reference comparison tick |
| chan_off | output | 1 | Channel is powered down |
| lock | output | 1 | Lock flag |

## Verification
A wrong divider count or a missed reload shows on `ref_tick` within one reference period, and it disturbs the pump pulse widths in the next comparison. A comparator flag that is stuck or cleared late shows within the same comparison, as a pump pulse that is too wide or missing. In the comparisons after that it also shows as a spurious lock loss. A lock counter or deferral register in the wrong state shows on `lock`, `chan_off` or `pump_hi` within one cycle of the event that should have moved it. The bench compares every output against its own cycle model on every cycle, so any divergence is reported at the first cycle it reaches a port.

// File: rtl/pll_phase_detect.sv
module pll_phase_detect #(
  parameter int RW = 15,
  parameter int LOCK_N = 4,
  parameter int THRESH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fb_pulse,
  input  logic [RW-1:0] ref_ratio,
  input  logic          pol_pos,
  input  logic          cp_hi,
  input  logic          cp_tri,
  input  logic          pd_req,
  input  logic          other_pd,
  input  logic          other_lock,
  input  logic [1:0]    stat_sel,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          pump_tri,
  output logic          pump_hi,
  output logic          stat_val,
  output logic          stat_drive,
  output logic          ref_tick,
  output logic          chan_off,
  output logic          lock
);
  localparam int CW = $clog2(LOCK_N + 1);
  localparam int EW = $clog2(THRESH + 1);
  localparam logic [RW-1:0] MIN_R = RW'(3);

  logic [RW-1:0] cnt, eff;
  logic          lead_q, lag_q, hi_q, off_q;
  logic [EW-1:0] ew;
  logic [CW-1:0] good;
  logic          halt, busy, bad, lead_in, lag_in, lock_ind;

  assign eff      = (ref_ratio < MIN_R) ? MIN_R : ref_ratio;
  assign halt     = off_q & other_pd;
  assign ref_tick = (cnt == '0) & ~halt;
  assign busy     = lead_q | lag_q;
  assign bad      = busy & (ew >= EW'(THRESH - 1));
  assign lead_in  = lead_q | (ref_tick & ~off_q);
  assign lag_in   = lag_q | (fb_pulse & ~off_q);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (halt)        cnt <= '0;
    else if (cnt == '0)   cnt <= eff - RW'(1);
    else                  cnt <= cnt - RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || off_q || (lead_in && lag_in)) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else begin
      lead_q <= lead_in;
      lag_q  <= lag_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy)       ew <= '0;
    else if (ew < EW'(THRESH)) ew <= ew + EW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || off_q || bad)                    good <= '0;
    else if (ref_tick && good < CW'(LOCK_N))       good <= good + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      hi_q <= 1'b0;
    else if (cp_hi)  hi_q <= 1'b1;
    else if (!busy)  hi_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pd_req) off_q <= 1'b0;
    else if (!busy)        off_q <= 1'b1;
  end

  assign lock     = (good == CW'(LOCK_N));
  assign lock_ind = lock & ~busy;
  assign chan_off = off_q;
  assign pump_hi  = hi_q;
  assign pump_tri = cp_tri | off_q;
  assign pump_up  = ~pump_tri & (pol_pos ? lead_q : lag_q);
  assign pump_dn  = ~pump_tri & (pol_pos ? lag_q : lead_q);

  always_comb begin
    case (stat_sel)
      2'd1:    begin stat_val = lock_ind;              stat_drive = 1'b1; end
      2'd2:    begin stat_val = lock_ind & other_lock; stat_drive = 1'b1; end
      2'd3:    begin stat_val = 1'b0;                  stat_drive = hi_q; end
      default: begin stat_val = 1'b0;                  stat_drive = 1'b1; end
    endcase
  end
endmodule

module pll_phase_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pump_up,
  input logic       pump_dn,
  input logic       pump_tri,
  input logic       pump_hi,
  input logic       chan_off,
  input logic       ref_tick,
  input logic       busy,
  input logic [1:0] stat_sel,
  input logic       stat_val,
  input logic       stat_drive
);
  assert_pump_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));
  assert_tri_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pump_tri |-> (!pump_up && !pump_dn));
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);
  assert_pd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_off) |-> $past(!busy));
  assert_hi_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pump_hi) |-> $past(!busy));
  assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_sel == 2'd0) |-> (stat_drive && !stat_val));
endmodule

bind pll_phase_detect pll_phase_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pump_up(pump_up), .pump_dn(pump_dn),
  .pump_tri(pump_tri), .pump_hi(pump_hi), .chan_off(chan_off),
  .ref_tick(ref_tick), .busy(lead_q | lag_q), .stat_sel(stat_sel),
  .stat_val(stat_val), .stat_drive(stat_drive)
);

// File: tb/test_pll_phase_detect.sv
module test_pll_phase_detect;
  localparam int CLK_T = 10;
  localparam int RW = 15;
  localparam int LN = 4;
  localparam int TH = 3;

  logic clk = 0, rst_n = 0, fb_pulse = 0, pol_pos = 1, cp_hi = 0, cp_tri = 0;
  logic pd_req = 0, other_pd = 0, other_lock = 1;
  logic [RW-1:0] ref_ratio = 5;
  logic [1:0] stat_sel = 1;
  logic pump_up, pump_dn, pump_tri, pump_hi, stat_val, stat_drive, ref_tick, chan_off, lock;
  int checks = 0, errors = 0;

  always #(CLK_T/2) clk = ~clk;

  pll_phase_detect #(.RW(RW), .LOCK_N(LN), .THRESH(TH)) i_pll_phase_detect (
    .clk(clk), .rst_n(rst_n), .fb_pulse(fb_pulse), .ref_ratio(ref_ratio),
    .pol_pos(pol_pos), .cp_hi(cp_hi), .cp_tri(cp_tri), .pd_req(pd_req),
    .other_pd(other_pd), .other_lock(other_lock), .stat_sel(stat_sel),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_tri(pump_tri), .pump_hi(pump_hi),
    .stat_val(stat_val), .stat_drive(stat_drive), .ref_tick(ref_tick),
    .chan_off(chan_off), .lock(lock));

  // cycle model built from the requirements
  int m_cnt = 0, m_w = 0, m_good = 0;
  bit m_lead = 0, m_lag = 0, m_hi = 0, m_off = 0;

  function automatic bit m_tick();
    return (m_cnt == 0) && !(m_off && other_pd);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_w = 0; m_good = 0; m_lead = 0; m_lag = 0; m_hi = 0; m_off = 0;
    end else begin
      int eff, n_cnt, n_w, n_good;
      bit tk, busy, bad, u, d, nl, ng, n_hi, n_off;
      eff  = (ref_ratio < 3) ? 3 : int'(ref_ratio);
      tk   = m_tick();
      busy = m_lead || m_lag;
      bad  = busy && (m_w >= TH - 1);
      u = m_lead || (tk && !m_off);
      d = m_lag || (fb_pulse && !m_off);
      if (m_off && other_pd) n_cnt = 0;
      else n_cnt = (m_cnt == 0) ? eff - 1 : m_cnt - 1;
      if (m_off || (u && d)) begin nl = 0; ng = 0; end else begin nl = u; ng = d; end
      n_w = !busy ? 0 : ((m_w < TH) ? m_w + 1 : m_w);
      n_good = (m_off || bad) ? 0 : ((tk && m_good < LN) ? m_good + 1 : m_good);
      n_hi = cp_hi ? 1'b1 : (busy ? m_hi : 1'b0);
      n_off = !pd_req ? 1'b0 : (!busy ? 1'b1 : m_off);
      m_cnt = n_cnt; m_lead = nl; m_lag = ng; m_w = n_w; m_good = n_good;
      m_hi = n_hi; m_off = n_off;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit tri_e, li;
    int sv, sd;
    tri_e = cp_tri || m_off;
    li = (m_good == LN) && !(m_lead || m_lag);
    case (stat_sel)
      2'd1: begin sv = li; sd = 1; end
      2'd2: begin sv = li && other_lock; sd = 1; end
      2'd3: begin sv = 0; sd = m_hi; end
      default: begin sv = 0; sd = 1; end
    endcase
    chk("R1 R2 R11 ref_tick", ref_tick, m_tick());
    chk("R3 R4 R5 pump_up", pump_up, !tri_e && (pol_pos ? m_lead : m_lag));
    chk("R3 R4 R5 pump_dn", pump_dn, !tri_e && (pol_pos ? m_lag : m_lead));
    chk("R5 pump_tri", pump_tri, tri_e);
    chk("R6 lock", lock, m_good == LN);
    chk("R7 R8 stat_val", stat_val, sv);
    chk("R8 stat_drive", stat_drive, sd);
    chk("R9 pump_hi", pump_hi, m_hi);
    chk("R10 chan_off", chan_off, m_off);
  endtask

  int lag_left = -1;
  int lag_set = 1;

  task automatic cycle(input bit randomize_modes, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (randomize_modes) begin
        if ($urandom_range(0, 40) == 0) pol_pos = $urandom_range(0, 1);
        if ($urandom_range(0, 30) == 0) stat_sel = $urandom_range(0, 3);
        if ($urandom_range(0, 25) == 0) cp_hi = $urandom_range(0, 1);
        if ($urandom_range(0, 60) == 0) cp_tri = $urandom_range(0, 1);
        if ($urandom_range(0, 50) == 0) pd_req = $urandom_range(0, 1);
        if ($urandom_range(0, 40) == 0) other_pd = $urandom_range(0, 1);
        if ($urandom_range(0, 20) == 0) other_lock = $urandom_range(0, 1);
        if ($urandom_range(0, 80) == 0) ref_ratio = RW'($urandom_range(0, 9));
        if ($urandom_range(0, 30) == 0) lag_set = $urandom_range(0, 5);
      end
      fb_pulse = 0;
      if (lag_left > 0) lag_left--;
      if (m_tick() && lag_left < 0) lag_left = lag_set;
      if (lag_left == 0) begin fb_pulse = 1; lag_left = -1; end
      if (randomize_modes && $urandom_range(0, 60) == 0) fb_pulse = 1;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state R1 R3 R6 R10
    chk("R1 reset tick", ref_tick, 1);
    chk("R6 reset lock", lock, 0);
    chk("R10 reset chan_off", chan_off, 0);
    chk("R3 reset pump", pump_up | pump_dn, 0);
    // directed: feedback one cycle late locks the loop (R6) with width-1 pulses
    lag_set = 1;
    cycle(0, 60);
    chk("R6 locked after aligned run", lock, 1);
    // directed: large lag breaks lock (R6)
    lag_set = 4;
    cycle(0, 30);
    chk("R6 lock lost on wide error", lock, 0);
    // directed: ratio below 3 (R2) and swapped polarity (R4)
    ref_ratio = 1; pol_pos = 0; lag_set = 0;
    cycle(0, 40);
    // directed: boost exit and deferred powerdown (R9 R10), divider halt (R11)
    cp_hi = 1; lag_set = 2; cycle(0, 10);
    cp_hi = 0; cycle(0, 10);
    pd_req = 1; cycle(0, 10);
    other_pd = 1; cycle(0, 10);
    chk("R11 divider halted", ref_tick, 0);
    other_pd = 0; pd_req = 0; cycle(0, 10);
    // random mix
    ref_ratio = 5; pol_pos = 1;
    cycle(1, 8000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_T * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule